// File: doc/BRIEF.md
# Micro-op Sampling Tagger

This block picks one micro-op out of the dispatch stream for detailed profiling and follows it until it leaves the pipeline. A 20-bit running count is compared against a programmable limit. When the count reaches the limit, one op is marked, and the block times that op's journey to retirement. The result is a sample record. The record holds three latencies: cycles from tag to retire, cycles from completion to retire, and data-cache miss service time. It also holds a small flag field.

Two selection modes exist. In op mode the count advances by the number of ops in each dispatch group. The op whose position makes the count reach the limit is the one marked. In cycle mode the count advances once per cycle. When it expires, the group dispatched in that cycle is used, and a rotating pointer picks one op within it. If no group is dispatched in that cycle, the chance is dropped and counting starts over.

Software can load both the running count and the limit, which lets it randomise the sampling period. A record is produced only when the marked op retires. A flushed (wrong-path) op leaves no trace. A finished record is held until it is acknowledged.

Top module: `op_sample_tagger`

## Requirements
- R1: After reset, tag_fire, trk_busy and smp_valid are all 0.
- R2: With sel_mode=0 (op mode), each dispatched group adds grp_size (1..3) to the count. When count+grp_size >= limit, tag_fire is raised in that same cycle. tag_slot is limit-count-1, where slot 0 is the oldest op of the group. The count then returns to zero.
- R3: With sel_mode=1 (cycle mode), the count advances once per armed, enabled cycle. When count+1 >= limit and a group is present in that cycle, tag_fire is raised with tag_slot = (pointer mod grp_size). The pointer is 2 bits wide, starts at 0 after reset, and advances once per cycle-mode tag.
- R4: In cycle mode, if no group is present when the count expires, no tag is made and the count restarts from zero.
- R5: When the tagged op retires (tag_retire while trk_busy), smp_valid rises at that edge and trk_busy falls. smp_t2r is the number of clock edges from the tag edge to the retire edge.
- R6: smp_c2r is the number of edges from the completion edge (tag_complete) to the retire edge. It is 0 when completion coincides with retire or never arrives.
- R7: A tag_dcmiss while tracking sets flag bit 0 of smp_flags. smp_mlat counts the edges from the miss edge to the completion edge; it is 0 when no miss occurred.
- R8: tag_flush while trk_busy ends tracking with no record, even if tag_retire is present in the same cycle. The count restarts from zero.
- R9: No tag is made while trk_busy or smp_valid is set. smp_valid and the record hold until smp_ack, and counting then resumes from zero.
- R10: ld_cur_en loads the count and ld_max_en loads the limit at the next edge. A count load overrides any counting update in that cycle.
- R11: With enable low, the count does not advance and no tag is made.
- R12: Flag bit 1 of smp_flags records the selection mode in force when the op was tagged (1 = cycle mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Sampling enable |
| sel_mode | input | 1 | 0 = count ops, 1 = count cycles |
| ld_cur_en | input | 1 | Load running count |
| ld_cur_val | input | 20 | Running count load value |
| ld_max_en | input | 1 | Load limit |
| ld_max_val | input | 20 | Limit load value |
| grp_valid | input | 1 | Dispatch group present this cycle |
| grp_size | input | 2 | Ops in the group (1..3) |
| tag_complete | input | 1 | Tagged op completed |
| tag_retire | input | 1 | Tagged op retired |
| tag_flush | input | 1 | Tagged op flushed |
| tag_dcmiss | input | 1 | Tagged op missed in the data cache |
| smp_ack | input | 1 | Record consumed |
| tag_fire | output | 1 | An op of the current group is tagged |
| tag_slot | output | 2 | Position of the tagged op in the group |
| trk_busy | output | 1 | A tagged op is in flight |
| smp_valid | output | 1 | Record available |
| smp_t2r | output | 16 | Tag-to-retire cycles |
| smp_c2r | output | 16 | Completion-to-retire cycles |
| smp_mlat | output | 16 | Miss latency cycles |
| smp_flags | output | 2 | bit0 data-cache miss, bit1 cycle mode |

## Verification
tag_fire and tag_slot are combinational on the current group and count. The bench drives a group after a falling edge and reads them one time step later, before the rising edge. Count and limit loads take effect at the next rising edge. So the bench expects the first expiry to show in the cycle after the load edge, and then one cycle later per further count step. Records appear at the retire edge. The bench samples them at the following falling edge and expects each latency to equal the number of rising edges it stepped between the two events.

// File: rtl/otag_pkg.sv
// Shared types for the op sampling tagger.
// Assumes: flag bit positions are fixed; both flag bits are read by software.
package otag_pkg;
    typedef enum logic { SEL_OPS = 1'b0, SEL_CYC = 1'b1 } sel_mode_e;
    typedef enum logic { ST_IDLE = 1'b0, ST_TRACK = 1'b1 } trk_state_e;
    localparam int FLG_W      = 2;
    localparam int FLG_DCMISS = 0;
    localparam int FLG_CYC    = 1;
endpackage

// File: rtl/otag_select.sv
// Selection counter: holds running count, limit and rotating pointer, and
// decides in the current cycle whether an op of the present group is tagged.
// Assumes: grp_size is 1..3 when grp_valid; arm is low while an op is in
// flight or a record is pending; restart pulses when tracking ends.
module otag_select
    import otag_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int GRP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  sel_mode_e        sel_mode,
    input  logic             arm,
    input  logic             restart,
    input  logic             ld_cur_en,
    input  logic [CNT_W-1:0] ld_cur_val,
    input  logic             ld_max_en,
    input  logic [CNT_W-1:0] ld_max_val,
    input  logic             grp_valid,
    input  logic [GRP_W-1:0] grp_size,
    output logic             tag_fire,
    output logic [GRP_W-1:0] tag_slot
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cur_q, cur_d, max_q, gap;
    logic [GRP_W-1:0] ptr_q, ptr_d;
    logic [EXT_W-1:0] sum, nxt, max_ext;

    // Pointer modulo group size; an illegal size of 0 picks slot 0.
    function automatic logic [GRP_W-1:0] rot_pick(input logic [GRP_W-1:0] p,
                                                  input logic [GRP_W-1:0] n);
        logic [GRP_W-1:0] r;
        r = '0;
        if (n != '0) r = p % n;
        return r;
    endfunction

    assign sum     = {1'b0, cur_q} + {{(EXT_W-GRP_W){1'b0}}, grp_size};
    assign nxt     = {1'b0, cur_q} + 1'b1;
    assign max_ext = {1'b0, max_q};
    assign gap     = max_q - cur_q - 1'b1;

    // Tag decision and next count for both selection modes.
    always_comb begin
        tag_fire = 1'b0;
        tag_slot = '0;
        cur_d    = cur_q;
        ptr_d    = ptr_q;
        if (enable && arm) begin
            if (sel_mode == SEL_OPS) begin
                if (grp_valid) begin
                    if (sum >= max_ext) begin
                        tag_fire = 1'b1;
                        tag_slot = (cur_q >= max_q) ? '0 : gap[GRP_W-1:0];
                        cur_d    = '0;
                    end else begin
                        cur_d = sum[CNT_W-1:0];
                    end
                end
            end else begin
                if (nxt >= max_ext) begin
                    cur_d = '0;
                    if (grp_valid) begin
                        tag_fire = 1'b1;
                        tag_slot = rot_pick(ptr_q, grp_size);
                        ptr_d    = ptr_q + 1'b1;
                    end
                end else begin
                    cur_d = nxt[CNT_W-1:0];
                end
            end
        end
        if (restart)   cur_d = '0;
        if (ld_cur_en) cur_d = ld_cur_val;
    end

    // Count, pointer and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            ptr_q <= '0;
            max_q <= '0;
        end else begin
            cur_q <= cur_d;
            ptr_q <= ptr_d;
            if (ld_max_en) max_q <= ld_max_val;
        end
    end
endmodule

// File: rtl/otag_track.sv
// Tracker: follows one tagged op to retirement or flush, times its stages
// and holds the finished record until acknowledged.
// Assumes: tag_fire only arrives while idle with no pending record; the
// per-op inputs refer to the tagged op and are ignored while idle.
module otag_track
    import otag_pkg::*;
#(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_fire,
    input  sel_mode_e        tag_mode,
    input  logic             tag_complete,
    input  logic             tag_retire,
    input  logic             tag_flush,
    input  logic             tag_dcmiss,
    input  logic             smp_ack,
    output logic             busy,
    output logic             restart,
    output logic             smp_valid,
    output logic [LAT_W-1:0] smp_t2r,
    output logic [LAT_W-1:0] smp_c2r,
    output logic [LAT_W-1:0] smp_mlat,
    output logic [FLG_W-1:0] smp_flags
);
    trk_state_e       state_q;
    logic [LAT_W-1:0] t2r_q, c2r_q, ml_q, mhold_q;
    logic             cmp_seen_q, miss_seen_q, miss_pend_q, cyc_q;
    logic             done_ok;

    // Saturating increment for all latency counters.
    function automatic logic [LAT_W-1:0] sat_inc(input logic [LAT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    assign busy    = (state_q == ST_TRACK);
    assign restart = busy && (tag_flush || tag_retire);
    assign done_ok = busy && tag_retire && !tag_flush;

    // Tracking state machine and in-flight timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            t2r_q       <= '0;
            c2r_q       <= '0;
            ml_q        <= '0;
            mhold_q     <= '0;
            cmp_seen_q  <= 1'b0;
            miss_seen_q <= 1'b0;
            miss_pend_q <= 1'b0;
            cyc_q       <= 1'b0;
        end else if (!busy) begin
            if (tag_fire) begin
                state_q     <= ST_TRACK;
                t2r_q       <= '0;
                c2r_q       <= '0;
                ml_q        <= '0;
                mhold_q     <= '0;
                cmp_seen_q  <= 1'b0;
                miss_seen_q <= 1'b0;
                miss_pend_q <= 1'b0;
                cyc_q       <= (tag_mode == SEL_CYC);
            end
        end else if (tag_flush || tag_retire) begin
            state_q <= ST_IDLE;
        end else begin
            t2r_q <= sat_inc(t2r_q);
            if (tag_complete && !cmp_seen_q) begin
                cmp_seen_q <= 1'b1;
                c2r_q      <= '0;
            end else if (cmp_seen_q) begin
                c2r_q <= sat_inc(c2r_q);
            end
            if (tag_dcmiss && !miss_seen_q) begin
                miss_seen_q <= 1'b1;
                miss_pend_q <= !tag_complete;
                ml_q        <= '0;
            end else if (miss_pend_q) begin
                if (tag_complete) begin
                    mhold_q     <= sat_inc(ml_q);
                    miss_pend_q <= 1'b0;
                end else begin
                    ml_q <= sat_inc(ml_q);
                end
            end
        end
    end

    // Record capture on retirement, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_t2r   <= '0;
            smp_c2r   <= '0;
            smp_mlat  <= '0;
            smp_flags <= '0;
        end else if (done_ok) begin
            smp_valid             <= 1'b1;
            smp_t2r               <= sat_inc(t2r_q);
            smp_c2r               <= cmp_seen_q ? sat_inc(c2r_q) : '0;
            smp_mlat              <= miss_pend_q ? sat_inc(ml_q) : mhold_q;
            smp_flags[FLG_DCMISS] <= miss_seen_q || tag_dcmiss;
            smp_flags[FLG_CYC]    <= cyc_q;
        end else if (smp_ack) begin
            smp_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/op_sample_tagger.sv
// Top of the op sampling tagger: joins the selection counter and tracker.
// Assumes: one tagged op at a time; selection is armed only when no op is
// in flight and no record awaits acknowledge.
module op_sample_tagger
    import otag_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int GRP_W = 2,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sel_mode,
    input  logic             ld_cur_en,
    input  logic [CNT_W-1:0] ld_cur_val,
    input  logic             ld_max_en,
    input  logic [CNT_W-1:0] ld_max_val,
    input  logic             grp_valid,
    input  logic [GRP_W-1:0] grp_size,
    input  logic             tag_complete,
    input  logic             tag_retire,
    input  logic             tag_flush,
    input  logic             tag_dcmiss,
    input  logic             smp_ack,
    output logic             tag_fire,
    output logic [GRP_W-1:0] tag_slot,
    output logic             trk_busy,
    output logic             smp_valid,
    output logic [LAT_W-1:0] smp_t2r,
    output logic [LAT_W-1:0] smp_c2r,
    output logic [LAT_W-1:0] smp_mlat,
    output logic [FLG_W-1:0] smp_flags
);
    sel_mode_e mode;
    logic      arm, restart;

    assign mode = sel_mode_e'(sel_mode);
    assign arm  = !trk_busy && !smp_valid;

    otag_select #(.CNT_W(CNT_W), .GRP_W(GRP_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sel_mode   (mode),
        .arm        (arm),
        .restart    (restart),
        .ld_cur_en  (ld_cur_en),
        .ld_cur_val (ld_cur_val),
        .ld_max_en  (ld_max_en),
        .ld_max_val (ld_max_val),
        .grp_valid  (grp_valid),
        .grp_size   (grp_size),
        .tag_fire   (tag_fire),
        .tag_slot   (tag_slot)
    );

    otag_track #(.LAT_W(LAT_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .tag_fire     (tag_fire),
        .tag_mode     (mode),
        .tag_complete (tag_complete),
        .tag_retire   (tag_retire),
        .tag_flush    (tag_flush),
        .tag_dcmiss   (tag_dcmiss),
        .smp_ack      (smp_ack),
        .busy         (trk_busy),
        .restart      (restart),
        .smp_valid    (smp_valid),
        .smp_t2r      (smp_t2r),
        .smp_c2r      (smp_c2r),
        .smp_mlat     (smp_mlat),
        .smp_flags    (smp_flags)
    );
endmodule

// File: rtl/op_sample_tagger_chk.sv
// Port-level protocol checks for the op sampling tagger, bound to the top.
module op_sample_tagger_chk #(
    parameter int GRP_W = 2,
    parameter int LAT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             grp_valid,
    input logic [GRP_W-1:0] grp_size,
    input logic             tag_flush,
    input logic             smp_ack,
    input logic             tag_fire,
    input logic [GRP_W-1:0] tag_slot,
    input logic             trk_busy,
    input logic             smp_valid,
    input logic [LAT_W-1:0] smp_t2r
);
    assert_tag_only_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_fire |-> (!trk_busy && !smp_valid));

    assert_slot_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tag_fire |-> (grp_valid && (tag_slot < grp_size)));

    assert_busy_after_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tag_fire |=> trk_busy);

    assert_record_from_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_valid) |-> $past(trk_busy));

    assert_flush_no_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_busy && tag_flush) |=> (!smp_valid && !trk_busy));

    assert_record_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ack) |=> (smp_valid && $stable(smp_t2r)));

    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tag_fire);
endmodule

bind op_sample_tagger op_sample_tagger_chk #(.GRP_W(GRP_W), .LAT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .grp_valid (grp_valid),
    .grp_size  (grp_size),
    .tag_flush (tag_flush),
    .smp_ack   (smp_ack),
    .tag_fire  (tag_fire),
    .tag_slot  (tag_slot),
    .trk_busy  (trk_busy),
    .smp_valid (smp_valid),
    .smp_t2r   (smp_t2r)
);

// File: tb/op_sample_tagger_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module op_sample_tagger_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, sel_mode, ld_cur_en, ld_max_en;
    logic [19:0] ld_cur_val, ld_max_val;
    logic        grp_valid;
    logic [1:0]  grp_size;
    logic        tag_complete, tag_retire, tag_flush, tag_dcmiss, smp_ack;
    logic        tag_fire, trk_busy, smp_valid;
    logic [1:0]  tag_slot, smp_flags;
    logic [15:0] smp_t2r, smp_c2r, smp_mlat;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    op_sample_tagger u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel_mode(sel_mode),
        .ld_cur_en(ld_cur_en), .ld_cur_val(ld_cur_val),
        .ld_max_en(ld_max_en), .ld_max_val(ld_max_val),
        .grp_valid(grp_valid), .grp_size(grp_size),
        .tag_complete(tag_complete), .tag_retire(tag_retire),
        .tag_flush(tag_flush), .tag_dcmiss(tag_dcmiss), .smp_ack(smp_ack),
        .tag_fire(tag_fire), .tag_slot(tag_slot), .trk_busy(trk_busy),
        .smp_valid(smp_valid), .smp_t2r(smp_t2r), .smp_c2r(smp_c2r),
        .smp_mlat(smp_mlat), .smp_flags(smp_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one rising edge and return at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic grp(input logic v, input int n);
        grp_valid = v;
        grp_size  = 2'(n);
        #1;
    endtask

    task automatic load(input logic lc, input int c, input logic lm, input int m);
        ld_cur_en = lc; ld_cur_val = 20'(c);
        ld_max_en = lm; ld_max_val = 20'(m);
        step();
        ld_cur_en = 0; ld_max_en = 0;
    endtask

    task automatic pulse_flush();
        grp(0, 0);
        tag_flush = 1; step(); tag_flush = 0;
    endtask

    task automatic t_reset();
        chk("R1 tag_fire", tag_fire, 0);
        chk("R1 trk_busy", trk_busy, 0);
        chk("R1 smp_valid", smp_valid, 0);
    endtask

    task automatic t_op_mode();
        sel_mode = 0;
        load(1, 0, 1, 5);
        grp(1, 3); chk("R2 below limit", tag_fire, 0); step();
        grp(1, 3); chk("R2 crossing fire", tag_fire, 1);
        chk("R2 crossing slot", tag_slot, 1);
        step();                       // tag edge E
        grp(0, 0);
        chk("R5 busy after tag", trk_busy, 1);
        tag_complete = 1; step(); tag_complete = 0;   // E+1
        step();                                        // E+2
        tag_retire = 1; step(); tag_retire = 0;        // E+3
        chk("R5 valid", smp_valid, 1);
        chk("R5 busy cleared", trk_busy, 0);
        chk("R5 t2r", smp_t2r, 3);
        chk("R6 c2r", smp_c2r, 2);
        chk("R7 no miss lat", smp_mlat, 0);
        chk("R12 op-mode flags", smp_flags, 0);
    endtask

    task automatic t_hold_ack();
        for (int i = 0; i < 3; i++) begin
            grp(1, 3); chk("R9 no tag while pending", tag_fire, 0); step();
        end
        chk("R9 record held", smp_t2r, 3);
        grp(0, 0); smp_ack = 1; step(); smp_ack = 0;
        chk("R9 ack clears", smp_valid, 0);
        grp(1, 3); chk("R9 restart from zero", tag_fire, 0); step();
        grp(1, 2); chk("R9 resumed fire", tag_fire, 1);
        chk("R9 resumed slot", tag_slot, 1);
        step(); grp(0, 0);
        chk("R9 busy", trk_busy, 1);
    endtask

    task automatic t_flush();
        tag_flush = 1; tag_retire = 1; step(); tag_flush = 0; tag_retire = 0;
        chk("R8 flush beats retire valid", smp_valid, 0);
        chk("R8 flush clears busy", trk_busy, 0);
        grp(1, 3); chk("R8 count from zero", tag_fire, 0); step();
        grp(1, 3); chk("R8 fire after restart", tag_fire, 1);
        chk("R8 slot after restart", tag_slot, 1);
        step(); pulse_flush();
        chk("R8 plain flush valid", smp_valid, 0);
    endtask

    task automatic t_miss();
        load(0, 0, 1, 1);
        grp(1, 2); chk("R2 limit 1 fire", tag_fire, 1);
        chk("R2 limit 1 slot", tag_slot, 0);
        step(); grp(0, 0);                              // E
        tag_dcmiss = 1; step(); tag_dcmiss = 0;         // E+1
        step(); step();                                 // E+3
        tag_complete = 1; step(); tag_complete = 0;     // E+4
        tag_retire = 1; step(); tag_retire = 0;         // E+5
        chk("R7 valid", smp_valid, 1);
        chk("R7 miss lat", smp_mlat, 3);
        chk("R7 miss flag", smp_flags, 1);
        chk("R5 t2r long", smp_t2r, 5);
        chk("R6 c2r short", smp_c2r, 1);
        smp_ack = 1; step(); smp_ack = 0;
    endtask

    task automatic t_load();
        load(1, 7, 1, 8);
        grp(1, 3); chk("R10 loaded count fire", tag_fire, 1);
        chk("R10 loaded slot", tag_slot, 0);
        step(); pulse_flush();
    endtask

    task automatic t_enable();
        enable = 0;
        for (int i = 0; i < 3; i++) begin
            grp(1, 3); chk("R11 no tag disabled", tag_fire, 0); step();
        end
        enable = 1;
        grp(1, 3); chk("R11 count held", tag_fire, 0); step();
        grp(1, 3); chk("R11 count held 2", tag_fire, 0); step();
        grp(1, 3); chk("R11 fire after enable", tag_fire, 1);
        chk("R11 slot", tag_slot, 1);
        step(); pulse_flush();
    endtask

    task automatic t_cycle();
        sel_mode = 1;
        load(1, 0, 1, 4);
        for (int i = 0; i < 3; i++) begin
            grp(1, 3); chk("R3 counting cycles", tag_fire, 0); step();
        end
        grp(1, 3); chk("R3 expiry fire", tag_fire, 1);
        chk("R3 pointer 0 slot", tag_slot, 0);
        step(); grp(0, 0);                         // E
        step();                                    // E+1
        tag_retire = 1; step(); tag_retire = 0;    // E+2
        chk("R5 cycle t2r", smp_t2r, 2);
        chk("R12 cycle flag", smp_flags, 2);
        chk("R6 no completion", smp_c2r, 0);
        smp_ack = 1; step(); smp_ack = 0;
        load(1, 3, 0, 0);
        grp(1, 2); chk("R3 pointer 1 fire", tag_fire, 1);
        chk("R3 pointer 1 mod 2", tag_slot, 1);
        step(); pulse_flush();
        load(1, 3, 0, 0);
        grp(1, 3); chk("R3 pointer 2 fire", tag_fire, 1);
        chk("R3 pointer 2 mod 3", tag_slot, 2);
        step(); pulse_flush();
    endtask

    task automatic t_skip();
        load(1, 3, 0, 0);
        grp(0, 0); chk("R4 no group no tag", tag_fire, 0); step();
        for (int i = 0; i < 3; i++) begin
            grp(1, 1); chk("R4 restarted count", tag_fire, 0); step();
        end
        grp(1, 1); chk("R4 next expiry fire", tag_fire, 1);
        chk("R4 slot single", tag_slot, 0);
        step(); pulse_flush();
    endtask

    initial begin
        rst_n = 0; enable = 1; sel_mode = 0;
        ld_cur_en = 0; ld_cur_val = 0; ld_max_en = 0; ld_max_val = 0;
        grp_valid = 0; grp_size = 0;
        tag_complete = 0; tag_retire = 0; tag_flush = 0; tag_dcmiss = 0; smp_ack = 0;
        @(negedge clk); step(); step();
        rst_n = 1; #1;
        t_reset();
        t_op_mode();
        t_hold_ack();
        t_flush();
        t_miss();
        t_load();
        t_enable();
        t_cycle();
        t_skip();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule